// File: doc/BRIEF.md
# Parallel Printer Byte Transmitter

This block is the host side of a one-way, printer-style parallel link. A byte offered on a valid/ready input is placed on eight output data lines. The block then waits until the peripheral reports it is not busy and holds the data steady for a set-up interval. It drives an active-low strobe for a fixed width, keeps the data for a hold interval, and then waits for the peripheral's acknowledge pulse to end. The set-up, strobe-width and hold intervals are counted in clock cycles through parameters. Their defaults give 500 ns each at 50 MHz.

Each byte runs in one of two modes, chosen when the byte is accepted. In automatic mode the strobe sequence starts as soon as the byte is taken. When the acknowledge returns, a one-cycle request for the next byte is raised. In manual mode the byte sits on the lines until a separate fire pulse arrives. The busy and acknowledge inputs pass through two-flop synchronizers. An optional interrupt pulse marks each rising acknowledge edge. If no acknowledge arrives within a programmable number of cycles, the block raises an error flag and goes back to idle.

Top module: `lpt_tx`

## Requirements
- R1: After reset, strobe_n is 1, in_ready is 1, pd_data is 0, and next_req, irq and timeout_err are 0.
- R2: Bytes accepted on in_valid/in_ready appear on pd_data in acceptance order, and each one is on pd_data when strobe_n falls.
- R3: strobe_n does not fall while busy_in is held at 1. After busy_in drops to 0, the strobe falls no sooner than SETUP_CYC+2 cycles later, which covers the synchronizer and the set-up interval.
- R4: pd_data has been unchanged for at least SETUP_CYC cycles when strobe_n falls.
- R5: strobe_n stays at 0 for exactly PULSE_CYC cycles per byte.
- R6: pd_data stays unchanged for at least HOLD_CYC cycles after strobe_n rises.
- R7: A byte accepted with auto_mode=0 is not strobed until fire is pulsed. A byte accepted with auto_mode=1 is strobed without fire.
- R8: The rising edge of the acknowledge (ack_n_in going 0 to 1) ends a byte taken in automatic mode and raises next_req for exactly one cycle. A byte taken in manual mode never raises next_req.
- R9: When irq_en is 1, each rising edge of ack_n_in gives a one-cycle pulse on irq. When irq_en is 0, irq stays 0.
- R10: If no acknowledge rise is seen within TIMEOUT_CYC cycles of the hold interval ending, timeout_err goes to 1 and in_ready returns to 1. timeout_err clears when the next byte is accepted.
- R11: in_ready is 0 from the cycle a byte is accepted until that byte completes or times out, including the whole strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1: strobe starts on its own; sampled when a byte is accepted |
| irq_en | input | 1 | Enables the interrupt pulse on acknowledge rise |
| fire | input | 1 | Starts the strobe sequence for a byte taken in manual mode |
| in_data | input | DW | Byte to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Engine is idle and can take a byte |
| pd_data | output | DW | Parallel data lines |
| strobe_n | output | 1 | Active-low data strobe |
| busy_in | input | 1 | Peripheral busy, asynchronous |
| ack_n_in | input | 1 | Peripheral acknowledge, active low, asynchronous |
| next_req | output | 1 | One-cycle request for the next byte (automatic mode) |
| irq | output | 1 | One-cycle interrupt pulse on acknowledge rise |
| timeout_err | output | 1 | Acknowledge wait timed out |

## Verification
The main transfer is tried with several byte values in a row: alternating bits, all ones, all zeros and a single bit. A monitor compares what each strobe captures against a queue filled by the driver. This separates a wrong or reordered byte from a correct one. The same traffic runs with the interrupt enabled and then disabled, so a stuck or gated irq can be told apart from a working one. Manual-mode bytes and a byte held off by a forced busy level show whether the strobe waits for fire and for the synchronized busy release. A peripheral that never acknowledges exercises the timeout, and the byte after it checks that the error flag clears.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT_ACK
    } tx_state_e;

    // synchronized peripheral status, bit order fixed for the synchronizer
    typedef struct packed {
        logic ack_n;
        logic busy;
    } periph_stat_t;

    // per-byte context captured at acceptance
    typedef struct packed {
        logic auto_q;
        logic go_q;
        logic ack_seen;
    } tx_ctx_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [1:0] stage;
            always_ff @(posedge clk) begin
                if (rst) stage <= {2{RST_VAL[i]}};
                else     stage <= {stage[0], d[i]};
            end
            assign q[i] = stage[1];
        end
    endgenerate
endmodule

// File: rtl/lpt_ack_watch.sv
module lpt_ack_watch (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_s,
    input  logic irq_en,
    output logic ack_rise,
    output logic irq
);
    logic ack_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_prev <= 1'b1;
            irq      <= 1'b0;
        end else begin
            ack_prev <= ack_n_s;
            irq      <= irq_en & ack_rise;
        end
    end

    assign ack_rise = ack_n_s & ~ack_prev;

    // R9: an interrupt pulse follows a cycle in which acknowledge was high
    assert_irq_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ack_n_s));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
endmodule

// File: rtl/lpt_tx_fsm.sv
module lpt_tx_fsm
    import lpt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SETUP_CYC   = 25,
    parameter int PULSE_CYC   = 25,
    parameter int HOLD_CYC    = 25,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_mode,
    input  logic          fire,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          busy_s,
    input  logic          ack_rise,
    output logic [DW-1:0] pd_data,
    output logic          strobe_n,
    output logic          next_req,
    output logic          timeout_err
);
    localparam int unsigned MAXC = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, TIMEOUT_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] TOUT_LAST  = CW'(TIMEOUT_CYC - 1);

    tx_state_e       state, nxt;
    tx_ctx_t         ctx;
    logic [CW-1:0]   cnt;
    logic            accept;
    logic            ack_done;
    logic            tout_hit;
    logic            in_flight;

    assign in_ready  = (state == ST_IDLE);
    assign accept    = in_ready & in_valid;
    assign strobe_n  = (state != ST_STROBE);
    assign in_flight = (state == ST_STROBE) || (state == ST_HOLD) || (state == ST_WAIT_ACK);
    assign ack_done  = (state == ST_WAIT_ACK) && (ack_rise || ctx.ack_seen);
    assign tout_hit  = (state == ST_WAIT_ACK) && !ack_done && (cnt == TOUT_LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (in_valid) nxt = ST_ARMED;
            ST_ARMED:    if ((ctx.go_q || fire) && !busy_s) nxt = ST_SETUP;
            ST_SETUP:    if (cnt == SETUP_LAST) nxt = ST_STROBE;
            ST_STROBE:   if (cnt == PULSE_LAST) nxt = ST_HOLD;
            ST_HOLD:     if (cnt == HOLD_LAST)  nxt = ST_WAIT_ACK;
            ST_WAIT_ACK: if (ack_done || tout_hit) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            ctx         <= '0;
            pd_data     <= '0;
            next_req    <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            state    <= nxt;
            cnt      <= (nxt != state) ? '0 : cnt + 1'b1;
            next_req <= ack_done & ctx.auto_q;
            if (accept) begin
                pd_data      <= in_data;
                ctx.auto_q   <= auto_mode;
                ctx.go_q     <= auto_mode;
                ctx.ack_seen <= 1'b0;
                timeout_err  <= 1'b0;
            end else begin
                if (state == ST_ARMED && fire) ctx.go_q <= 1'b1;
                if (in_flight && ack_rise)     ctx.ack_seen <= 1'b1;
                if (tout_hit)                  timeout_err <= 1'b1;
            end
        end
    end

    // R11: no new byte is taken while the strobe is active
    assert_no_ready_in_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> !in_ready);

    // R8: the next-byte request is a single-cycle pulse
    assert_next_req_single_R8: assert property (@(posedge clk) disable iff (rst)
        next_req |=> !next_req);

    // R10: an error flag only appears when the engine is back at idle
    assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> in_ready);

    // R7: strobe never starts from idle directly
    assert_strobe_after_arm_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> !in_ready);
endmodule

// File: rtl/lpt_tx.sv
module lpt_tx
    import lpt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SETUP_CYC   = 25,
    parameter int PULSE_CYC   = 25,
    parameter int HOLD_CYC    = 25,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_mode,
    input  logic          irq_en,
    input  logic          fire,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [DW-1:0] pd_data,
    output logic          strobe_n,
    input  logic          busy_in,
    input  logic          ack_n_in,
    output logic          next_req,
    output logic          irq,
    output logic          timeout_err
);
    localparam int CW = $clog2(max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, 1) + 1);
    localparam logic [CW-1:0] SETUP_V = CW'(SETUP_CYC);
    localparam logic [CW-1:0] PULSE_V = CW'(PULSE_CYC);
    localparam logic [CW-1:0] HOLD_V  = CW'(HOLD_CYC);

    periph_stat_t raw_stat, sync_stat;
    logic         ack_rise;

    assign raw_stat.ack_n = ack_n_in;
    assign raw_stat.busy  = busy_in;

    lpt_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_stat),
        .q   (sync_stat)
    );

    lpt_ack_watch u_ack (
        .clk      (clk),
        .rst      (rst),
        .ack_n_s  (sync_stat.ack_n),
        .irq_en   (irq_en),
        .ack_rise (ack_rise),
        .irq      (irq)
    );

    lpt_tx_fsm #(
        .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .auto_mode   (auto_mode),
        .fire        (fire),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .busy_s      (sync_stat.busy),
        .ack_rise    (ack_rise),
        .pd_data     (pd_data),
        .strobe_n    (strobe_n),
        .next_req    (next_req),
        .timeout_err (timeout_err)
    );

    // pin-timing checker counters
    logic [CW-1:0] chk_low, chk_since, chk_hold;
    logic [DW-1:0] chk_pd_q;
    logic          chk_stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_low   <= '0;
            chk_since <= '0;
            chk_hold  <= '0;
            chk_pd_q  <= '0;
            chk_stb_q <= 1'b1;
        end else begin
            chk_pd_q  <= pd_data;
            chk_stb_q <= strobe_n;
            chk_low   <= strobe_n ? '0 : chk_low + 1'b1;
            if (pd_data != chk_pd_q)   chk_since <= '0;
            else if (chk_since != SETUP_V) chk_since <= chk_since + 1'b1;
            if (strobe_n && !chk_stb_q) chk_hold <= HOLD_V;
            else if (chk_hold != '0)    chk_hold <= chk_hold - 1'b1;
        end
    end

    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> (chk_low == PULSE_V));

    assert_setup_time_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> (chk_since >= SETUP_V));

    assert_hold_time_R6: assert property (@(posedge clk) disable iff (rst)
        (chk_hold != '0) |-> $stable(pd_data));
endmodule

// File: tb/sim_lpt_tx.sv
module sim_lpt_tx;
    localparam int SETUP = 25, PULSE = 25, HOLD = 25, TOUT = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_mode = 1'b1, irq_en = 1'b0, fire = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, strobe_n, next_req, irq, timeout_err;
    logic [7:0] pd_data;
    logic       busy_in = 1'b0, ack_n_in = 1'b1;

    int checks = 0, failures = 0;
    int cyc = 0;
    int falls = 0, nr_cnt = 0, irq_cnt = 0, last_fall_cyc = 0;
    bit periph_on = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpt_tx #(.DW(8), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
             .TIMEOUT_CYC(TOUT)) u0 (
        .clk(clk), .rst(rst), .auto_mode(auto_mode), .irq_en(irq_en), .fire(fire),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .pd_data(pd_data), .strobe_n(strobe_n), .busy_in(busy_in),
        .ack_n_in(ack_n_in), .next_req(next_req), .irq(irq),
        .timeout_err(timeout_err));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: offer a byte and record it as expected
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(in_ready && exp_q.size() == 0)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor / scoreboard
    bit         stb_prev = 1'b1;
    logic [7:0] pd_prev = 8'h00;
    int         since = 0, low_len = 0, hold_left = 0;
    logic [7:0] hold_val = 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            if (next_req) nr_cnt++;
            if (irq)      irq_cnt++;
            if (hold_left > 0) begin
                check(pd_data == hold_val, "R6", "data during hold", pd_data, hold_val);
                hold_left--;
            end
            if (!strobe_n)
                check(!in_ready, "R11", "in_ready while strobe low", in_ready, 0);
            if (stb_prev && !strobe_n) begin
                falls++;
                last_fall_cyc = cyc;
                low_len = 1;
                check(since >= SETUP, "R4", "setup cycles", since, SETUP);
                if (exp_q.size() == 0)
                    check(1'b0, "R2", "strobe with empty queue", pd_data, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(pd_data == e, "R2", "strobed byte", pd_data, e);
                end
            end else if (!strobe_n) begin
                low_len++;
            end else if (!stb_prev && strobe_n) begin
                check(low_len == PULSE, "R5", "strobe width", low_len, PULSE);
                hold_left = HOLD;
                hold_val  = pd_data;
            end
            since = (pd_data != pd_prev) ? 0 : since + 1;
        end
        stb_prev = strobe_n;
        pd_prev  = pd_data;
    end

    // peripheral model: busy after strobe, then acknowledge pulse
    initial begin
        forever begin
            @(posedge strobe_n);
            if (periph_on && !rst) begin
                repeat (3) @(negedge clk);
                busy_in = 1'b1;
                repeat (20) @(negedge clk);
                ack_n_in = 1'b0;
                repeat (30) @(negedge clk);
                busy_in  = 1'b0;
                ack_n_in = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int f0, n0, i0, rel;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(strobe_n == 1'b1, "R1", "strobe_n", strobe_n, 1);
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        check(pd_data == 8'h00, "R1", "pd_data", pd_data, 0);
        check({next_req, irq, timeout_err} == 3'b000, "R1", "flags", {next_req, irq, timeout_err}, 0);
        periph_on = 1'b1;

        // R2 R8 R9: automatic mode, interrupt enabled, several patterns
        auto_mode = 1'b1; irq_en = 1'b1;
        n0 = nr_cnt; i0 = irq_cnt;
        send_byte(8'hA5); send_byte(8'h5A); send_byte(8'hFF);
        send_byte(8'h00); send_byte(8'h01);
        wait_idle();
        check(nr_cnt - n0 == 5, "R8", "next_req pulses auto", nr_cnt - n0, 5);
        check(irq_cnt - i0 == 5, "R9", "irq pulses enabled", irq_cnt - i0, 5);
        check(timeout_err == 1'b0, "R10", "no timeout on good traffic", timeout_err, 0);

        // R9 interrupt disabled
        irq_en = 1'b0;
        n0 = nr_cnt; i0 = irq_cnt;
        send_byte(8'h3C); send_byte(8'hC3);
        wait_idle();
        check(irq_cnt == i0, "R9", "irq pulses disabled", irq_cnt - i0, 0);
        check(nr_cnt - n0 == 2, "R8", "next_req pulses auto 2", nr_cnt - n0, 2);

        // R7 R8 manual mode
        auto_mode = 1'b0;
        f0 = falls; n0 = nr_cnt;
        send_byte(8'h81);
        auto_mode = 1'b1;
        repeat (100) @(negedge clk);
        check(falls == f0, "R7", "no strobe before fire", falls - f0, 0);
        check(in_ready == 1'b0, "R11", "busy with pending byte", in_ready, 0);
        fire = 1'b1; @(negedge clk); fire = 1'b0;
        wait_idle();
        check(falls - f0 == 1, "R7", "strobe after fire", falls - f0, 1);
        check(nr_cnt == n0, "R8", "no next_req in manual", nr_cnt - n0, 0);

        // R3 busy held off
        busy_in = 1'b1;
        f0 = falls;
        send_byte(8'h7E);
        repeat (100) @(negedge clk);
        check(falls == f0, "R3", "no strobe while busy", falls - f0, 0);
        busy_in = 1'b0;
        rel = cyc;
        wait_idle();
        check(falls - f0 == 1, "R3", "strobe after busy release", falls - f0, 1);
        check(last_fall_cyc - rel >= SETUP + 2, "R3", "delay after release",
              last_fall_cyc - rel, SETUP + 2);

        // R10 timeout with silent peripheral
        periph_on = 1'b0;
        n0 = nr_cnt;
        send_byte(8'hE7);
        repeat (SETUP + PULSE + HOLD + TOUT + 20) @(negedge clk);
        check(timeout_err == 1'b1, "R10", "timeout flag", timeout_err, 1);
        check(in_ready == 1'b1, "R10", "idle after timeout", in_ready, 1);
        check(nr_cnt == n0, "R8", "no next_req on timeout", nr_cnt - n0, 0);
        periph_on = 1'b1;
        send_byte(8'h42);
        check(timeout_err == 1'b0, "R10", "flag cleared on accept", timeout_err, 0);
        wait_idle();
        check(timeout_err == 1'b0, "R10", "flag stays clear", timeout_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule